// File: doc/BRIEF.md
# Serial Register Access Frontend for an Eight-Channel Output Controller

This block is the serial slave of an eight-channel output controller. An external master drives chip select, serial clock and serial data, and the block samples all three in a fast system clock domain through a two-flop synchronizer. It then finds the pin edges from the synchronized levels. Each frame carries a two-bit command, a three-bit register address and an eight-bit data byte. When the frame ends, the block commits a register write, a register read, a full register reset or a plain diagnosis read. At the same time it issues a one-cycle pulse that clears the diagnosis latches of the neighbouring fault logic.

When a frame starts, the block loads a 16-bit word into its transmit register. Normally this is the diagnosis word from the fault logic. If the previous accepted frame was a read, it is the read response. The word is shifted out most significant bit first. The serial output is modelled as a data bit plus an output enable, so that a pad cell can turn it into a three-state pin. The block commits nothing if the number of clocks in the frame is not a non-zero multiple of eight, or if the command is illegal. The serial link has no back-pressure: the master sets the pace, and the block keeps up as long as each serial clock phase and each chip select level lasts several system clocks.

Top module: `octal_spi_frontend`

## Requirements
- R1: After reset, the input-map register reads 08h, the logic-mode, overload-mode, overtemperature-mode, slew and serial-control registers read 00h, the output enable is low, no read response is pending and the clear pulse is low.
- R2: While chip select is high, the output enable is low and the serial output is 0. Clock and data activity on the other pins changes no register and issues no clear pulse.
- R3: On the falling edge of chip select, the transmit word is loaded. Its bit 15 appears before the first rising serial clock edge, and each later rising edge presents the next lower bit. The serial input is sampled on falling serial clock edges, first bit received being the most significant.
- R4: A frame holds the command in bits 15:14, ignored bits in 13:11, the address in 10:8 and data in 7:0. Command 11 writes the data byte to address 1 (input map), 2 (logic mode), 3 (overload mode), 4 (overtemperature mode), 5 (slew) or 7 (serial control).
- R5: Command 01 with a non-zero address makes the next frame transmit 01000b in bits 15:11, the address in bits 10:8 and the register contents in bits 7:0. Address 6 returns the out_state input.
- R6: Command 10 returns every writable register to its reset value.
- R7: Command 00 changes no register, is a valid frame and makes the next frame transmit the diagnosis word.
- R8: A frame whose clock count is zero or not a multiple of eight changes nothing and issues no clear pulse.
- R9: Command 01 or 11 with address 0, and command 11 with address 6, are invalid. Such a frame changes no register, issues no clear pulse and leaves the choice of the next transmit word as it was.
- R10: Every valid frame produces exactly one single-cycle clear pulse, in the same cycle as its register update becomes visible.
- R11: In a frame longer than 16 clocks, the last 16 bits received are decoded. From bit 16 onward, the serial output repeats the serial input stream delayed by 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| diag_word | input | 16 | Diagnosis word from the fault logic |
| out_state | input | 8 | Read-only output-state byte |
| cfg_map | output | 8 | Input-map register |
| cfg_logic | output | 8 | Logic-mode register |
| cfg_ovl | output | 8 | Overload-mode register |
| cfg_ovt | output | 8 | Overtemperature-mode register |
| cfg_slew | output | 8 | Slew register |
| cfg_ctl | output | 8 | Serial-control register |
| diag_clr | output | 1 | One-cycle clear pulse for the diagnosis latches |

## Verification
Several properties are checked on every cycle: the output enable stays low once chip select has been high for a few cycles, the clear pulse never lasts two cycles and only occurs with chip select high, every register change coincides with a clear pulse, and reset leaves the default values. Other behaviours only show up across whole frames, so the bench scenarios cover them. These are the bit order on the serial output, the read response that appears one frame later, rejection of odd clock counts and illegal commands, survival of a pending read across an illegal frame, and the delayed echo of input bits in long frames.

// File: rtl/ospi_pkg.sv
package ospi_pkg;
  localparam int FRAME_W   = 16;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int CMD_W     = 2;
  localparam int NUM_SLOTS = 1 << ADDR_W;
  localparam int HDR_W     = FRAME_W - ADDR_W - DATA_W;
  localparam int SPARE_W   = FRAME_W - CMD_W - ADDR_W - DATA_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_DIAG  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_RESET = 2'b10,
    CMD_WRITE = 2'b11
  } ospi_cmd_e;

  typedef struct packed {
    ospi_cmd_e           cmd;
    logic [SPARE_W-1:0]  spare;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } ospi_frame_t;

  localparam logic [ADDR_W-1:0] ADR_NONE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MAP   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LOGIC = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_OVL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_OVT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SLEW  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STATE = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_CTL   = 3'd7;

  localparam logic [DATA_W-1:0] MAP_DEFAULT = 8'h08;
  localparam logic [HDR_W-1:0]  READ_HDR    = 5'b01000;

  function automatic logic [DATA_W-1:0] slot_default(input logic [ADDR_W-1:0] a);
    return (a == ADR_MAP) ? MAP_DEFAULT : '0;
  endfunction

  function automatic logic frame_legal(input ospi_cmd_e c, input logic [ADDR_W-1:0] a);
    case (c)
      CMD_DIAG, CMD_RESET: return 1'b1;
      CMD_READ:            return a != ADR_NONE;
      CMD_WRITE:           return (a != ADR_NONE) && (a != ADR_STATE);
      default:             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ospi_sync.sv
module ospi_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= INIT;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/ospi_shifter.sv
module ospi_shifter #(
  parameter int W      = 16,
  parameter int BYTE_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sample_i,
  input  logic         launch_i,
  input  logic         sdi_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] rx_o,
  output logic         sdo_o,
  output logic         len_ok_o
);
  localparam int CW = $clog2(BYTE_W);

  logic [W-1:0]  rx_q, tx_q;
  logic [CW-1:0] cnt_q;
  logic          byte_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      byte_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      tx_q   <= load_i;
      cnt_q  <= '0;
      byte_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (sample_i) begin
      rx_q   <= {rx_q[W-2:0], sdi_i};
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= 1'b1;
      if (cnt_q == CW'(BYTE_W - 1)) byte_q <= 1'b1;
    end else if (launch_i && seen_q) begin
      tx_q <= {tx_q[W-2:0], rx_q[0]};
    end
  end

  assign rx_o     = rx_q;
  assign sdo_o    = tx_q[W-1];
  assign len_ok_o = byte_q && (cnt_q == '0);
endmodule

// File: rtl/ospi_regbank.sv
module ospi_regbank
  import ospi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  ospi_cmd_e          cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [FRAME_W-1:0] diag_i,
  input  logic [DATA_W-1:0]  state_i,
  output logic [DATA_W-1:0]  cfg_o [NUM_SLOTS],
  output logic [FRAME_W-1:0] tx_word_o,
  output logic               diag_clr_o
);
  logic              take;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign take = commit_i && frame_legal(cmd_i, addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      rd_addr_q  <= '0;
      diag_clr_o <= 1'b0;
    end else begin
      diag_clr_o <= take;
      if (take) begin
        rd_pend_q <= (cmd_i == CMD_READ);
        rd_addr_q <= addr_i;
      end
    end
  end

  for (genvar a = 0; a < NUM_SLOTS; a++) begin : g_slot
    if (ADDR_W'(a) == ADR_NONE) begin : g_hole
      assign cfg_o[a] = '0;
    end else if (ADDR_W'(a) == ADR_STATE) begin : g_ro
      assign cfg_o[a] = state_i;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= slot_default(ADDR_W'(a));
        else if (take && cmd_i == CMD_RESET)
          q <= slot_default(ADDR_W'(a));
        else if (take && cmd_i == CMD_WRITE && addr_i == ADDR_W'(a))
          q <= data_i;
      end
      assign cfg_o[a] = q;
    end
  end

  assign tx_word_o = rd_pend_q ? {READ_HDR, rd_addr_q, cfg_o[rd_addr_q]} : diag_i;
endmodule

// File: rtl/octal_spi_frontend.sv
module octal_spi_frontend
  import ospi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_csn,
  input  logic        spi_sclk,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  input  logic [15:0] diag_word,
  input  logic [7:0]  out_state,
  output logic [7:0]  cfg_map,
  output logic [7:0]  cfg_logic,
  output logic [7:0]  cfg_ovl,
  output logic [7:0]  cfg_ovt,
  output logic [7:0]  cfg_slew,
  output logic [7:0]  cfg_ctl,
  output logic        diag_clr
);
  // synchronized pin levels: [2] chip select, [1] serial clock, [0] data in
  logic [2:0] lvl;
  logic [1:0] prev_q;
  logic       active_q;
  logic       cs_fall, cs_rise, ck_rise, ck_fall;
  logic       len_ok, sdo;
  logic [FRAME_W-1:0] rx_bits, tx_word;
  ospi_frame_t        rx_frame;
  logic               spare_unused;
  logic [DATA_W-1:0]  cfg_arr [NUM_SLOTS];

  ospi_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({spi_csn, spi_sclk, spi_mosi}),
    .level_o (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 2'b10;
      active_q <= 1'b0;
    end else begin
      prev_q <= lvl[2:1];
      if (cs_fall)      active_q <= 1'b1;
      else if (cs_rise) active_q <= 1'b0;
    end
  end

  assign cs_fall = prev_q[1] & ~lvl[2];
  assign cs_rise = ~prev_q[1] & lvl[2];
  assign ck_rise = ~prev_q[0] & lvl[1];
  assign ck_fall = prev_q[0] & ~lvl[1];

  ospi_shifter #(.W(FRAME_W), .BYTE_W(8)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cs_fall),
    .sample_i (active_q & ck_fall),
    .launch_i (active_q & ck_rise),
    .sdi_i    (lvl[0]),
    .load_i   (tx_word),
    .rx_o     (rx_bits),
    .sdo_o    (sdo),
    .len_ok_o (len_ok)
  );

  assign rx_frame     = ospi_frame_t'(rx_bits);
  assign spare_unused = ^rx_frame.spare;

  ospi_regbank u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (active_q & cs_rise & len_ok),
    .cmd_i      (rx_frame.cmd),
    .addr_i     (rx_frame.addr),
    .data_i     (rx_frame.data),
    .diag_i     (diag_word),
    .state_i    (out_state),
    .cfg_o      (cfg_arr),
    .tx_word_o  (tx_word),
    .diag_clr_o (diag_clr)
  );

  assign spi_miso_oe = active_q;
  assign spi_miso    = active_q & sdo;

  assign cfg_map   = cfg_arr[ADR_MAP];
  assign cfg_logic = cfg_arr[ADR_LOGIC];
  assign cfg_ovl   = cfg_arr[ADR_OVL];
  assign cfg_ovt   = cfg_arr[ADR_OVT];
  assign cfg_slew  = cfg_arr[ADR_SLEW];
  assign cfg_ctl   = cfg_arr[ADR_CTL];
endmodule

// File: rtl/ospi_checker.sv
module ospi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_csn,
  input logic        spi_miso_oe,
  input logic        diag_clr,
  input logic [47:0] cfg_all
);
  // R2: chip select held high for four samples forces the pad enable off
  a_r2_idle_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);

  // R2: commits happen only after chip select has returned high
  a_r2_commit_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |-> spi_csn);

  // R10: clear pulse lasts a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |=> !diag_clr);

  // R10: any register change comes with the clear pulse of its frame
  a_r10_change_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |-> diag_clr);

  // R1: registers hold their defaults right after reset is released
  a_r1_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_all == {8'h08, 40'h0} && !spi_miso_oe && !diag_clr));
endmodule

bind octal_spi_frontend ospi_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_csn     (spi_csn),
  .spi_miso_oe (spi_miso_oe),
  .diag_clr    (diag_clr),
  .cfg_all     ({cfg_map, cfg_logic, cfg_ovl, cfg_ovt, cfg_slew, cfg_ctl})
);

// File: tb/octal_spi_frontend_tb_top.sv
module octal_spi_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe, diag_clr;
  logic [15:0] diag_v = 16'hC35A;
  logic [7:0]  state_v = 8'hA5;
  logic [7:0]  cfg_map, cfg_logic, cfg_ovl, cfg_ovt, cfg_slew, cfg_ctl;

  always #4 clk = ~clk;

  octal_spi_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .diag_word(diag_v), .out_state(state_v),
    .cfg_map(cfg_map), .cfg_logic(cfg_logic), .cfg_ovl(cfg_ovl), .cfg_ovt(cfg_ovt),
    .cfg_slew(cfg_slew), .cfg_ctl(cfg_ctl), .diag_clr(diag_clr)
  );

  typedef struct {
    logic [31:0] exp;
    int          n;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] got_bits;
  event        frame_ev;
  int          checks = 0, errors = 0;
  int          clr_seen = 0, clr_exp = 0;

  // bench model
  logic [7:0] m [8];
  logic       pend = 1'b0;
  logic [2:0] paddr = 3'd0;

  function automatic logic [7:0] mval(input logic [2:0] a);
    return (a == 3'd6) ? state_v : m[a];
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    m[1] = 8'h08;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && diag_clr) clr_seen <= clr_seen + 1;

  // monitor: pops expected serial output and compares with what the driver captured
  initial begin
    forever begin
      @(frame_ev);
      if (exp_q.size() != 0) begin
        item_t it;
        logic [31:0] mask;
        it = exp_q.pop_front();
        mask = '0;
        for (int i = 0; i < it.n && i < 32; i++) mask[31-i] = 1'b1;
        chk({it.tag, " serial output"}, got_bits & mask, it.exp & mask);
      end
    end
  end

  task automatic chk_regs(input string tag);
    chk({tag, " map"},   {24'h0, cfg_map},   {24'h0, m[1]});
    chk({tag, " logic"}, {24'h0, cfg_logic}, {24'h0, m[2]});
    chk({tag, " ovl"},   {24'h0, cfg_ovl},   {24'h0, m[3]});
    chk({tag, " ovt"},   {24'h0, cfg_ovt},   {24'h0, m[4]});
    chk({tag, " slew"},  {24'h0, cfg_slew},  {24'h0, m[5]});
    chk({tag, " ctl"},   {24'h0, cfg_ctl},   {24'h0, m[7]});
  endtask

  // driver: stream s is sent from bit 31 downward, n clocks
  task automatic frame(input logic [31:0] s, input int n, input string tag);
    item_t       it;
    logic [15:0] w;
    logic [31:0] sh;
    logic [1:0]  c;
    logic [2:0]  a;
    logic [7:0]  d;
    bit          ok;
    int          oe_bad;
    w = pend ? {5'b01000, paddr, mval(paddr)} : diag_v;
    it.exp = {w, 16'h0};
    for (int k = 16; k < n; k++) it.exp[31-k] = s[31-(k-16)];
    it.n = n;
    it.tag = tag;
    exp_q.push_back(it);
    got_bits = '0;
    oe_bad = 0;
    spi_csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = s[31-i];
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
      got_bits[31-i] = spi_miso;
      if (!spi_miso_oe) oe_bad++;
      spi_sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    spi_csn = 1'b1;
    -> frame_ev;
    repeat (20) @(negedge clk);
    chk("R3 enable during frame", oe_bad, 0);
    if (n % 8 == 0 && n >= 16) begin
      sh = s << (n - 16);
      w  = sh[31:16];
      c  = w[15:14];
      a  = w[10:8];
      d  = w[7:0];
      ok = (c == 2'b00) || (c == 2'b10) || (c == 2'b01 && a != 3'd0) ||
           (c == 2'b11 && a != 3'd0 && a != 3'd6);
      if (ok) begin
        clr_exp++;
        pend  = (c == 2'b01);
        paddr = a;
        if (c == 2'b10) model_defaults();
        if (c == 2'b11) m[a] = d;
      end
    end
    chk_regs(tag);
    chk({tag, " clear pulses"}, clr_seen, clr_exp);
    chk("R2 idle pins", {30'h0, spi_miso_oe, spi_miso}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk_regs("R1");
    chk("R1 enable", {31'h0, spi_miso_oe}, 32'h0);
    chk("R1 clear", clr_seen, 0);

    frame({16'h0000, 16'h0}, 16, "R7");            // diagnosis only
    frame({16'hC13C, 16'h0}, 16, "R4");            // map write
    frame({16'hC781, 16'h0}, 16, "R4");            // ctl write
    frame({16'hC25A, 16'h0}, 16, "R4");
    frame({16'hC3F0, 16'h0}, 16, "R4");
    frame({16'hC40F, 16'h0}, 16, "R4");
    frame({16'hC5AA, 16'h0}, 16, "R4");
    diag_v = 16'h9E17;
    frame({16'h4200, 16'h0}, 16, "R3");            // read logic, sees new diag word
    frame({16'hC055, 16'h0}, 16, "R5");            // returns read data; address 0 invalid
    frame({16'h0000, 16'h0}, 16, "R9");            // read response survives invalid frame
    frame({16'h4600, 16'h0}, 16, "R5");            // read output-state byte
    frame({16'hC6FF, 16'h0}, 16, "R5");            // returns state; write to 6 invalid
    frame({16'h7800, 16'h0}, 16, "R9");            // read with address 0 is invalid
    frame({16'hC7FF, 16'h0}, 12, "R8");            // odd length discarded
    frame({16'hC2FF, 16'h0}, 5, "R8");
    frame({8'hE1, 16'hC333, 8'h0}, 24, "R11");     // long frame
    // R2: pin activity while deselected
    for (int i = 0; i < 12; i++) begin
      spi_mosi = i[0];
      repeat (3) @(negedge clk);
      spi_sclk = ~spi_sclk;
      repeat (3) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (10) @(negedge clk);
    chk_regs("R2");
    chk("R2 clear", clr_seen, clr_exp);
    chk("R2 enable", {31'h0, spi_miso_oe}, 32'h0);
    frame({16'h8000, 16'h0}, 16, "R6");            // restore defaults
    frame({16'h4100, 16'h0}, 16, "R10");
    frame({16'h0000, 16'h0}, 16, "R5");            // read of default map value
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule